// File: doc/BRIEF.md
# 8b/10b Line Encoder with Running Disparity

The block turns one byte per accepted cycle into a 10-bit symbol that is kept DC balanced. The five low bits of the byte go through a 5b/6b mapping and the three high bits go through a 3b/4b mapping. A one-bit running disparity state picks which of the two complementary forms of an unbalanced sub-code goes out. Because of this state, the symbol produced for a given byte depends on everything sent before it. A control flag tells the block to encode one of the twelve special characters. A control request that names any other byte raises an error and falls back to the data encoding.

The output is registered, so a symbol appears one cycle after its byte is accepted. The disparity state is shown on its own output. It is encoded as 0 for -1 and 1 for +1. A serialiser downstream sends bit 9 of the symbol first.

Top module: `line_enc_8b10b`

## Requirements
- R1: Byte bits [4:0] (EDCBA) map to symbol bits [9:4] (abcdei, a in bit 9). Byte bits [7:5] (HGF) map to symbol bits [3:0] (fghj, j in bit 0). Both mappings follow the standard 8b/10b data tables, for example D21.5 gives 1010101010 and D0.0 at disparity -1 gives 1001110100.
- R2: Every 6-bit and 4-bit sub-code has a ones-minus-zeros disparity of -2, 0 or +2. A +2 sub-code is sent only while the running disparity is -1, and a -2 sub-code only while it is +1.
- R3: The running disparity flips after each unbalanced sub-code. The 6-bit sub-code is resolved first, and the disparity it leaves behind selects the form of the 4-bit sub-code of the same byte.
- R4: On reset the running disparity is -1 (rd_o = 0), and valid_o and ctrl_err_o are 0.
- R5: The concatenated serial stream never holds more than 5 identical bits in a row. The alternate encoding 0111/1000 of high group 7 is used after low groups 17, 18 and 20 at disparity -1, and after low groups 11, 13 and 14 at disparity +1.
- R6: With ctrl_i set, twelve bytes are legal: K28.0 to K28.7 (low group 28, any high group) and K23.7, K27.7, K29.7, K30.7. K28.5 at disparity -1 gives 0011111010, K28.1 gives 0011111001 and K23.7 gives 1110101000. Any other byte raises ctrl_err_o with the symbol and is encoded as data.
- R7: sym_o, valid_o, ctrl_err_o and rd_o change one cycle after an accepted byte. When valid_i is low, valid_o is 0 on the next cycle and the running disparity holds its value.
- R8: rd_o always equals the disparity that remains after the last symbol sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on data_i is accepted this cycle |
| data_i | input | 8 | Byte to encode, HGF EDCBA |
| ctrl_i | input | 1 | Encode as a control character |
| sym_o | output | 10 | Encoded symbol, bit 9 sent first |
| valid_o | output | 1 | sym_o holds a new symbol |
| rd_o | output | 1 | Running disparity, 0 = -1, 1 = +1 |
| ctrl_err_o | output | 1 | Illegal control byte was requested |

## Verification
The hardest cases to reach are the alternate high-group-7 codes and the balanced sub-codes that still alternate (low group 7, high group 3, and the control high groups). Each one shows up only when a particular low group meets a particular running disparity, and that disparity is set by the history of earlier symbols. The directed vector list is ordered so that each earlier symbol leaves the disparity needed by the next one, and it lands on D17.7 at -1, D11.7 at +1, D20.7 at +1, and D7.3 on both sides. A long random stream then checks sub-code disparity, the state rule and run length on every symbol, including across gaps where valid_i is low and across illegal control requests.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
  localparam int unsigned LO_W  = 5;
  localparam int unsigned HI_W  = 3;
  localparam int unsigned BYTE_W = LO_W + HI_W;
  localparam int unsigned LO_CW = LO_W + 1;
  localparam int unsigned HI_CW = HI_W + 1;
  localparam int unsigned SYM_W = LO_CW + HI_CW;

  localparam logic [LO_W-1:0] K_LO = 5'd28;
  localparam logic [HI_W-1:0] G7   = 3'd7;

  // 0 = -1, 1 = +1
  typedef logic rd_t;
endpackage

// File: rtl/enc_lo6.sv
module enc_lo6
  import line_enc_pkg::*;
(
  input  logic [LO_W-1:0]  grp_i,
  input  logic             k28_i,
  input  rd_t              rd_i,
  output logic [LO_CW-1:0] code_o,
  output rd_t              rd_o
);
  logic [LO_CW-1:0] neg_form;
  logic             unbal, flip;

  // neg_form: form sent at disparity -1, abcdei
  always_comb begin
    unique case (grp_i)
      5'd0:  neg_form = 6'b100111;
      5'd1:  neg_form = 6'b011101;
      5'd2:  neg_form = 6'b101101;
      5'd3:  neg_form = 6'b110001;
      5'd4:  neg_form = 6'b110101;
      5'd5:  neg_form = 6'b101001;
      5'd6:  neg_form = 6'b011001;
      5'd7:  neg_form = 6'b111000;
      5'd8:  neg_form = 6'b111001;
      5'd9:  neg_form = 6'b100101;
      5'd10: neg_form = 6'b010101;
      5'd11: neg_form = 6'b110100;
      5'd12: neg_form = 6'b001101;
      5'd13: neg_form = 6'b101100;
      5'd14: neg_form = 6'b011100;
      5'd15: neg_form = 6'b010111;
      5'd16: neg_form = 6'b011011;
      5'd17: neg_form = 6'b100011;
      5'd18: neg_form = 6'b010011;
      5'd19: neg_form = 6'b110010;
      5'd20: neg_form = 6'b001011;
      5'd21: neg_form = 6'b101010;
      5'd22: neg_form = 6'b011010;
      5'd23: neg_form = 6'b111010;
      5'd24: neg_form = 6'b110011;
      5'd25: neg_form = 6'b100110;
      5'd26: neg_form = 6'b010110;
      5'd27: neg_form = 6'b110110;
      5'd28: neg_form = k28_i ? 6'b001111 : 6'b001110;
      5'd29: neg_form = 6'b101110;
      5'd30: neg_form = 6'b011110;
      default: neg_form = 6'b101011;
    endcase
  end

  assign unbal  = ($countones(neg_form) != (LO_CW / 2));
  // group 7 is balanced but still alternates to break long runs
  assign flip   = unbal || ((grp_i == 5'd7) && !k28_i);
  assign code_o = (rd_i && flip) ? ~neg_form : neg_form;
  assign rd_o   = unbal ? ~rd_i : rd_i;
endmodule

// File: rtl/enc_hi4.sv
module enc_hi4
  import line_enc_pkg::*;
(
  input  logic [HI_W-1:0]  grp_i,
  input  logic             ctrl_i,
  input  logic             alt7_i,
  input  rd_t              rd_i,
  output logic [HI_CW-1:0] code_o,
  output rd_t              rd_o
);
  logic [HI_CW-1:0] neg_form;
  logic             unbal, flip;

  // neg_form: form sent at disparity -1, fghj
  always_comb begin
    if (ctrl_i) begin
      unique case (grp_i)
        3'd0: neg_form = 4'b1011;
        3'd1: neg_form = 4'b0110;
        3'd2: neg_form = 4'b1010;
        3'd3: neg_form = 4'b1100;
        3'd4: neg_form = 4'b1101;
        3'd5: neg_form = 4'b0101;
        3'd6: neg_form = 4'b1001;
        default: neg_form = 4'b0111;
      endcase
    end else begin
      unique case (grp_i)
        3'd0: neg_form = 4'b1011;
        3'd1: neg_form = 4'b1001;
        3'd2: neg_form = 4'b0101;
        3'd3: neg_form = 4'b1100;
        3'd4: neg_form = 4'b1101;
        3'd5: neg_form = 4'b1010;
        3'd6: neg_form = 4'b0110;
        default: neg_form = alt7_i ? 4'b0111 : 4'b1110;
      endcase
    end
  end

  assign unbal  = ($countones(neg_form) != (HI_CW / 2));
  assign flip   = unbal || ctrl_i || (grp_i == 3'd3);
  assign code_o = (rd_i && flip) ? ~neg_form : neg_form;
  assign rd_o   = unbal ? ~rd_i : rd_i;
endmodule

// File: rtl/line_enc_8b10b.sv
module line_enc_8b10b
  import line_enc_pkg::*;
#(
  parameter bit RD_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ctrl_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              valid_o,
  output logic              rd_o,
  output logic              ctrl_err_o
);
  logic [LO_W-1:0]  lo_grp;
  logic [HI_W-1:0]  hi_grp;
  logic             k_ok, k28, alt7;
  logic [LO_CW-1:0] lo_code;
  logic [HI_CW-1:0] hi_code;
  rd_t              rd_q, rd_mid, rd_end;

  assign lo_grp = data_i[LO_W-1:0];
  assign hi_grp = data_i[BYTE_W-1:LO_W];

  always_comb begin
    k28  = (lo_grp == K_LO);
    k_ok = ctrl_i && (k28 || ((hi_grp == G7) &&
           (lo_grp == 5'd23 || lo_grp == 5'd27 || lo_grp == 5'd29 || lo_grp == 5'd30)));
  end

  enc_lo6 u_lo (
    .grp_i (lo_grp),
    .k28_i (k_ok && k28),
    .rd_i  (rd_q),
    .code_o(lo_code),
    .rd_o  (rd_mid)
  );

  // alternate 7 avoids a run of 5 across the sub-code boundary
  always_comb begin
    alt7 = 1'b0;
    if (hi_grp == G7) begin
      if (k_ok)
        alt7 = 1'b1;
      else if (!rd_mid)
        alt7 = (lo_grp == 5'd17) || (lo_grp == 5'd18) || (lo_grp == 5'd20);
      else
        alt7 = (lo_grp == 5'd11) || (lo_grp == 5'd13) || (lo_grp == 5'd14);
    end
  end

  enc_hi4 u_hi (
    .grp_i (hi_grp),
    .ctrl_i(k_ok),
    .alt7_i(alt7),
    .rd_i  (rd_mid),
    .code_o(hi_code),
    .rd_o  (rd_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= RD_INIT;
      sym_o      <= '0;
      valid_o    <= 1'b0;
      ctrl_err_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        rd_q       <= rd_end;
        sym_o      <= {lo_code, hi_code};
        ctrl_err_o <= ctrl_i && !k_ok;
      end else begin
        ctrl_err_o <= 1'b0;
      end
    end
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/line_enc_8b10b_chk.sv
module line_enc_8b10b_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [9:0] sym_o,
  input logic       valid_o,
  input logic       rd_o,
  input logic       ctrl_err_o
);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(rd_o)));

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  sub_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (($countones(sym_o[9:4]) inside {2, 3, 4}) &&
                 ($countones(sym_o[3:0]) inside {1, 2, 3})));

  // R8
  heavy_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i ##1 ($countones(sym_o) == 6)) |-> (rd_o && !$past(rd_o)));

  // R8
  light_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i ##1 ($countones(sym_o) == 4)) |-> (!rd_o && $past(rd_o)));

  // R6
  err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_err_o |-> valid_o);
endmodule

bind line_enc_8b10b line_enc_8b10b_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .sym_o     (sym_o),
  .valid_o   (valid_o),
  .rd_o      (rd_o),
  .ctrl_err_o(ctrl_err_o)
);

// File: tb/tb_line_enc_8b10b.sv
module tb_line_enc_8b10b;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = '0;
  logic       ctrl = 1'b0;
  logic [9:0] sym;
  logic       vout, rd, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_enc_8b10b dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data), .ctrl_i(ctrl),
    .sym_o(sym), .valid_o(vout), .rd_o(rd), .ctrl_err_o(err)
  );

  // {ctrl, byte, symbol, rd after, err}, sequence from reset
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hBC, 10'b0011111010, 1'b1, 1'b0},
    {1'b1, 8'hBC, 10'b1100000101, 1'b0, 1'b0},
    {1'b0, 8'hB5, 10'b1010101010, 1'b0, 1'b0},
    {1'b0, 8'h00, 10'b1001110100, 1'b0, 1'b0},
    {1'b0, 8'h67, 10'b1110001100, 1'b0, 1'b0},
    {1'b0, 8'hF1, 10'b1000110111, 1'b1, 1'b0},
    {1'b0, 8'hEB, 10'b1101001000, 1'b0, 1'b0},
    {1'b0, 8'hE3, 10'b1100011110, 1'b1, 1'b0},
    {1'b0, 8'h3F, 10'b0101001001, 1'b0, 1'b0},
    {1'b1, 8'hF7, 10'b1110101000, 1'b0, 1'b0},
    {1'b1, 8'h3C, 10'b0011111001, 1'b1, 1'b0},
    {1'b1, 8'h00, 10'b0110001011, 1'b1, 1'b1},
    {1'b0, 8'h67, 10'b0001110011, 1'b1, 1'b0},
    {1'b1, 8'hFC, 10'b1100000111, 1'b1, 1'b0},
    {1'b0, 8'hF4, 10'b0010110001, 1'b0, 1'b0}
  };

  localparam logic [7:0] KLIST [12] = '{
    8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
    8'hF7, 8'hFB, 8'hFD, 8'hFE
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic c, input logic [7:0] b);
    valid = v; ctrl = c; data = b;
    @(posedge clk); #1;
  endtask

  function automatic bit legal_k(input logic [7:0] b);
    foreach (KLIST[i]) if (KLIST[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  // stream model for random phase
  bit rd_m;
  bit last_bit;
  int run;

  task automatic stream_check(input logic c, input logic [7:0] b);
    int d6, d4;
    d6 = 2 * $countones(sym[9:4]) - 6;
    d4 = 2 * $countones(sym[3:0]) - 4;
    // R2 R3: first sub-code
    chk("R2 lo sub-code disparity", (d6 == 0) || (d6 == 2 && !rd_m) || (d6 == -2 && rd_m), 1);
    if (d6 != 0) rd_m = ~rd_m;
    chk("R3 hi sub-code follows mid disparity", (d4 == 0) || (d4 == 2 && !rd_m) || (d4 == -2 && rd_m), 1);
    if (d4 != 0) rd_m = ~rd_m;
    chk("R8 rd_o tracks stream", rd, rd_m);
    chk("R6 error flag", err, c && !legal_k(b));
    for (int i = 9; i >= 0; i--) begin
      if (sym[i] == last_bit) run++;
      else begin last_bit = sym[i]; run = 1; end
      if (run > 5) chk("R5 run length", run, 5);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    // R4 reset state
    chk("R4 rd at reset", rd, 0);
    chk("R4 valid at reset", vout, 0);
    chk("R4 err at reset", err, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 R3 R5 R6 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R1/R6 symbol vec %0d", i), sym, VEC[i][11:2]);
      chk($sformatf("R8 rd vec %0d", i), rd, VEC[i][1]);
      chk($sformatf("R6 err vec %0d", i), err, VEC[i][0]);
      chk($sformatf("R7 valid vec %0d", i), vout, 1);
    end

    // R7: idle holds disparity; K28.5 leaves +1
    drive(1'b1, 1'b1, 8'hBC);
    chk("R7 rd before idle", rd, 1);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, 8'h55);
      chk("R7 valid low when idle", vout, 0);
      chk("R7 rd held when idle", rd, 1);
      chk("R7 no error when idle", err, 0);
    end
    drive(1'b1, 1'b0, 8'h00);
    chk("R7 D0.0 after idle at +1", sym, 10'b0110001011);

    // R4 reset mid-stream
    #1 rst_n = 1'b0;
    #1;
    chk("R4 rd after reset", rd, 0);
    chk("R4 valid after reset", vout, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    drive(1'b1, 1'b1, 8'hBC);
    chk("R4 K28.5 from reset", sym, 10'b0011111010);

    // random stream: R2 R3 R5 R6 R8
    rd_m = rd; last_bit = sym[0]; run = 1;
    for (int n = 0; n < 4000; n++) begin
      logic v, c;
      logic [7:0] b;
      int r;
      r = $urandom_range(0, 99);
      v = (r < 85);
      c = (r < 15);
      b = $urandom_range(0, 255);
      if (c && (r < 12)) b = KLIST[$urandom_range(0, 11)];
      drive(v, c, b);
      if (v) stream_check(c, b);
      else chk("R7 idle valid", vout, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule